// File: doc/BRIEF.md
# Split-Carry Effective Address Generator

This block forms a 32-bit effective address on a 16-bit datapath as base plus scaled index plus displacement. The base is one of three 32-bit special registers (program counter, stack pointer, frame base pointer) or a pair of 16-bit general registers. An index register value and a scale code arrive one cycle earlier with a prefix instruction. The unit holds them until the next memory instruction uses them.

The low half of the address is summed in the cycle after a request is accepted. If that sum carries into the upper word, or the displacement is negative, the unit spends one stall cycle and adjusts the upper word. In every other case the upper word of the base passes through untouched. Memory access is outside this block.

The controller is a three-state machine:
- `ST_IDLE`: nothing pending.
- `ST_HIGH`: the stall cycle in which the upper word is adjusted.
- `ST_OUT`: the finished address is presented.

Its transitions are:
- IDLE/OUT to OUT on an accepted request that needs no adjustment.
- IDLE/OUT to HIGH on an accepted request that needs an adjustment.
- HIGH to OUT when the adjustment completes.
- OUT to IDLE when no request arrives.
- Any state to IDLE on a flush.

Top module: `ea_gen_top`

## Requirements
- R1: After reset, `addr_valid` and `stall` are 0 and no prefix is held, so an indexed request issued first uses an index of zero.
- R2: `base_sel` picks the base: 0 = `pc_in`, 1 = `sp_in`, 2 = `bp_in`, 3 = `{pair_hi, pair_lo}`.
- R3: An accepted request whose displacement is non-negative and whose low-half sum produces no carry raises `addr_valid` one cycle later with no stall. The upper address word then equals the base's upper word.
- R4: An accepted request whose low-half sum carries, or whose displacement has bit 15 set, raises `stall` for exactly one cycle, one cycle after acceptance. `addr_valid` follows one cycle later with the full sum modulo 2^32.
- R5: With `req_mode` = 1 the held index is zero-extended and multiplied by 2^`pfx_scale` (codes 0..3 give 1, 2, 4, 8) before being added. The displacement is always sign-extended from 16 bits.
- R6: With `req_mode` = 0 any held index is ignored; the address is base plus displacement.
- R7: A held prefix is consumed by the next accepted request of either mode; a later indexed request without a new prefix uses index zero.
- R8: `flush` clears the held prefix, cancels a pending stall cycle so that no `addr_valid` follows, and discards a request presented in the same cycle.
- R9: A request presented while `stall` is high is ignored and produces no address.
- R10: A prefix presented in the same cycle as a request is not used by that request but is held for the following one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush |
| pfx_valid | input | 1 | Prefix instruction present |
| pfx_index | input | 16 | Index register value from prefix |
| pfx_scale | input | 2 | Scale code from prefix |
| req_valid | input | 1 | Memory instruction present |
| req_mode | input | 1 | 0 = base+disp, 1 = base+scaled index+disp |
| base_sel | input | 2 | Base source select |
| req_disp | input | 16 | Signed displacement |
| pc_in | input | 32 | Program counter |
| sp_in | input | 32 | Stack pointer |
| bp_in | input | 32 | Frame base pointer |
| pair_hi | input | 16 | Upper register of the general pair |
| pair_lo | input | 16 | Lower register of the general pair |
| addr | output | 32 | Effective address |
| addr_valid | output | 1 | Address complete this cycle |
| stall | output | 1 | Upper-word adjustment cycle |

## Verification
A request presented before clock edge E gives `addr_valid` in the cycle right after E on the fast path. On the slow path it gives `stall` in that cycle and `addr_valid` in the cycle after it. A prefix takes effect on the request that follows its own edge. The bench drives every input on a falling edge and reads outputs on the next falling edge, one rising edge later. Per request it predicts the fast or slow path from its own 32-bit sum and samples `stall` and `addr` in exactly those cycles. For flush and ignored-request cases it also samples the cycle after, to confirm no stray valid.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
    typedef enum logic [1:0] {
        BASE_PC   = 2'd0,
        BASE_SP   = 2'd1,
        BASE_BP   = 2'd2,
        BASE_PAIR = 2'd3
    } base_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_OUT  = 2'd2
    } ea_state_e;
endpackage

// File: rtl/ea_prefix_hold.sv
module ea_prefix_hold #(
    parameter int HW  = 16,
    parameter int SCW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic           load,
    input  logic [HW-1:0]  load_index,
    input  logic [SCW-1:0] load_scale,
    input  logic           consume,
    output logic           held,
    output logic [HW-1:0]  held_index,
    output logic [SCW-1:0] held_scale
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held       <= 1'b0;
            held_index <= '0;
            held_scale <= '0;
        end else if (flush) begin
            held       <= 1'b0;
        end else if (load) begin
            held       <= 1'b1;
            held_index <= load_index;
            held_scale <= load_scale;
        end else if (consume) begin
            held       <= 1'b0;
        end
    end

    // R8: flush leaves nothing held
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !held);
    // R7: a use without a fresh prefix drops the held one
    a_r7_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !load && !flush) |=> !held);
    // R10: a prefix arriving with a request survives it
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !flush) |=> held);
endmodule

// File: rtl/ea_low_stage.sv
module ea_low_stage
    import ea_gen_pkg::*;
#(
    parameter int HW  = 16,
    parameter int SCW = 2,
    parameter int AW  = 2 * HW,
    parameter int MAXSH = (1 << SCW) - 1,
    parameter int CW  = MAXSH + 2
) (
    input  base_sel_e      sel,
    input  logic [AW-1:0]  pc,
    input  logic [AW-1:0]  sp,
    input  logic [AW-1:0]  bp,
    input  logic [HW-1:0]  pr_hi,
    input  logic [HW-1:0]  pr_lo,
    input  logic           use_index,
    input  logic [HW-1:0]  index,
    input  logic [SCW-1:0] scale,
    input  logic [HW-1:0]  disp,
    output logic [HW-1:0]  base_hi,
    output logic [HW-1:0]  low_word,
    output logic [CW-1:0]  carry,
    output logic           neg
);
    localparam int SW = HW + MAXSH;
    localparam int TW = HW + CW;

    logic [AW-1:0] base;
    logic [SW-1:0] shift_opts [0:MAXSH];
    logic [SW-1:0] scaled;
    logic [TW-1:0] sum;

    always_comb begin
        unique case (sel)
            BASE_PC:   base = pc;
            BASE_SP:   base = sp;
            BASE_BP:   base = bp;
            BASE_PAIR: base = {pr_hi, pr_lo};
            default:   base = pc;
        endcase
    end

    for (genvar s = 0; s <= MAXSH; s++) begin : g_shift
        assign shift_opts[s] = SW'({{MAXSH{1'b0}}, index} << s);
    end

    assign scaled   = use_index ? shift_opts[scale] : '0;
    assign sum      = TW'(base[HW-1:0]) + TW'(scaled) + TW'(disp);
    assign base_hi  = base[AW-1:HW];
    assign low_word = sum[HW-1:0];
    assign carry    = sum[TW-1:HW];
    assign neg      = disp[HW-1];
endmodule

// File: rtl/ea_high_adj.sv
module ea_high_adj #(
    parameter int HW = 16,
    parameter int CW = 5
) (
    input  logic [HW-1:0] hi_in,
    input  logic [CW-1:0] carry,
    input  logic          neg,
    output logic [HW-1:0] hi_out
);
    assign hi_out = hi_in + HW'(carry) + (neg ? {HW{1'b1}} : {HW{1'b0}});
endmodule

// File: rtl/ea_gen_top.sv
module ea_gen_top
    import ea_gen_pkg::*;
#(
    parameter int HW  = 16,
    parameter int SCW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              pfx_valid,
    input  logic [HW-1:0]     pfx_index,
    input  logic [SCW-1:0]    pfx_scale,
    input  logic              req_valid,
    input  logic              req_mode,
    input  logic [1:0]        base_sel,
    input  logic [HW-1:0]     req_disp,
    input  logic [2*HW-1:0]   pc_in,
    input  logic [2*HW-1:0]   sp_in,
    input  logic [2*HW-1:0]   bp_in,
    input  logic [HW-1:0]     pair_hi,
    input  logic [HW-1:0]     pair_lo,
    output logic [2*HW-1:0]   addr,
    output logic              addr_valid,
    output logic              stall
);
    localparam int AW    = 2 * HW;
    localparam int MAXSH = (1 << SCW) - 1;
    localparam int CW    = MAXSH + 2;

    ea_state_e state_q, state_d;

    logic           accept;
    logic           held;
    logic [HW-1:0]  held_index;
    logic [SCW-1:0] held_scale;
    logic [HW-1:0]  base_hi, low_word, hi_adj;
    logic [CW-1:0]  carry;
    logic           neg, need_adj;

    logic [HW-1:0]  hi_q, lo_q;
    logic [CW-1:0]  carry_q;
    logic           neg_q;

    assign accept = req_valid && !flush && (state_q != ST_HIGH);

    ea_prefix_hold #(.HW(HW), .SCW(SCW)) u_pfx (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .load       (pfx_valid),
        .load_index (pfx_index),
        .load_scale (pfx_scale),
        .consume    (accept),
        .held       (held),
        .held_index (held_index),
        .held_scale (held_scale)
    );

    ea_low_stage #(.HW(HW), .SCW(SCW)) u_low (
        .sel       (base_sel_e'(base_sel)),
        .pc        (pc_in),
        .sp        (sp_in),
        .bp        (bp_in),
        .pr_hi     (pair_hi),
        .pr_lo     (pair_lo),
        .use_index (req_mode && held),
        .index     (held_index),
        .scale     (held_scale),
        .disp      (req_disp),
        .base_hi   (base_hi),
        .low_word  (low_word),
        .carry     (carry),
        .neg       (neg)
    );

    ea_high_adj #(.HW(HW), .CW(CW)) u_hi (
        .hi_in  (hi_q),
        .carry  (carry_q),
        .neg    (neg_q),
        .hi_out (hi_adj)
    );

    assign need_adj = (carry != '0) || neg;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = ST_IDLE;
        if (!flush) begin
            unique case (state_q)
                ST_HIGH: state_d = ST_OUT;
                ST_IDLE,
                ST_OUT:  state_d = accept ? (need_adj ? ST_HIGH : ST_OUT) : ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // address words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            carry_q <= '0;
            neg_q   <= 1'b0;
        end else if (accept) begin
            hi_q    <= base_hi;
            lo_q    <= low_word;
            carry_q <= carry;
            neg_q   <= neg;
        end else if (state_q == ST_HIGH) begin
            hi_q    <= hi_adj;
        end
    end

    // outputs
    always_comb begin
        addr       = {hi_q, lo_q};
        addr_valid = 1'b0;
        stall      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIGH: stall      = 1'b1;
            ST_OUT:  addr_valid = 1'b1;
            default: ;
        endcase
    end

    // R4: stall never lasts two cycles
    a_r4_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    // R4: an uninterrupted stall is followed by the address
    a_r4_stall_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> addr_valid);
    // R4: the low word is untouched by the adjustment cycle
    a_r4_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (addr[HW-1:0] == $past(addr[HW-1:0])));
    // R3: fast path hands through the upper base word
    a_r3_pass_high: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !need_adj) |=> (addr_valid && addr[AW-1:HW] == $past(base_hi)));
    // R8: flush leaves no result behind
    a_r8_flush_kills: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!addr_valid && !stall));
    // R9: stall and valid never together
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({stall, addr_valid}) <= 1);
endmodule

// File: tb/sim_ea_gen_top.sv
module sim_ea_gen_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        pfx_valid = 1'b0;
    logic [15:0] pfx_index = '0;
    logic [1:0]  pfx_scale = '0;
    logic        req_valid = 1'b0;
    logic        req_mode = 1'b0;
    logic [1:0]  base_sel = '0;
    logic [15:0] req_disp = '0;
    logic [31:0] pc_in = '0, sp_in = '0, bp_in = '0;
    logic [15:0] pair_hi = '0, pair_lo = '0;
    logic [31:0] addr;
    logic        addr_valid, stall;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    ea_gen_top u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .pfx_valid(pfx_valid), .pfx_index(pfx_index), .pfx_scale(pfx_scale),
        .req_valid(req_valid), .req_mode(req_mode), .base_sel(base_sel),
        .req_disp(req_disp), .pc_in(pc_in), .sp_in(sp_in), .bp_in(bp_in),
        .pair_hi(pair_hi), .pair_lo(pair_lo),
        .addr(addr), .addr_valid(addr_valid), .stall(stall)
    );

    // fields: sel(2) mode(1) scale(2) index(16) disp(16) base(32)
    localparam int NV = 8;
    localparam logic [68:0] VEC [0:NV-1] = '{
        {2'd0, 1'b0, 2'd0, 16'h0000, 16'h0010, 32'h0001_0020},
        {2'd1, 1'b0, 2'd0, 16'h0000, 16'h0020, 32'h0002_FFF0},
        {2'd2, 1'b0, 2'd0, 16'h0000, 16'hFFF0, 32'h0005_0100},
        {2'd3, 1'b1, 2'd1, 16'h0010, 16'h0004, 32'h1234_0000},
        {2'd0, 1'b1, 2'd3, 16'hFFFF, 16'h0000, 32'h0000_0000},
        {2'd1, 1'b1, 2'd2, 16'h1000, 16'h8000, 32'h0010_8000},
        {2'd2, 1'b1, 2'd0, 16'h0001, 16'hFFFF, 32'h0000_0000},
        {2'd3, 1'b0, 2'd0, 16'h0000, 16'h7FFF, 32'hFFFF_8001}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [31:0] ea(input logic [31:0] base, input bit use_idx,
                                       input logic [1:0] sc, input logic [15:0] idx,
                                       input logic [15:0] d);
        logic [31:0] off;
        off = use_idx ? ({16'h0, idx} * (32'd1 << sc)) : 32'd0;
        return base + off + {{16{d[15]}}, d};
    endfunction

    function automatic bit slow(input logic [31:0] base, input logic [31:0] e, input logic [15:0] d);
        return d[15] || (e[31:16] != base[31:16]);
    endfunction

    task automatic set_base(input logic [1:0] sel, input logic [31:0] base);
        base_sel = sel;
        pc_in = 32'hA5A5_0001; sp_in = 32'h5A5A_0002; bp_in = 32'h3C3C_0003;
        pair_hi = 16'hC3C3; pair_lo = 16'h0004;
        case (sel)
            2'd0: pc_in = base;
            2'd1: sp_in = base;
            2'd2: bp_in = base;
            default: {pair_hi, pair_lo} = base;
        endcase
    endtask

    task automatic prefix(input logic [15:0] idx, input logic [1:0] sc);
        pfx_valid = 1'b1; pfx_index = idx; pfx_scale = sc;
        step();
        pfx_valid = 1'b0;
    endtask

    // present a request for one edge, then read the outcome
    task automatic request(input string tag, input logic [1:0] sel, input bit mode,
                           input logic [15:0] d, input logic [31:0] base,
                           input logic [31:0] exp, input bit exp_slow);
        set_base(sel, base);
        req_mode = mode; req_disp = d; req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        if (exp_slow) begin
            chk({tag, " R4 stall"}, stall === 1'b1 && addr_valid === 1'b0, {31'd0, stall}, 32'd1);
            step();
            chk({tag, " R4 addr"}, addr_valid === 1'b1 && stall === 1'b0 && addr === exp, addr, exp);
        end else begin
            chk({tag, " R3 addr"}, addr_valid === 1'b1 && stall === 1'b0 && addr === exp, addr, exp);
        end
        step();
    endtask

    initial begin
        repeat (3) step();
        // R1: reset state
        chk("R1 idle outputs", addr_valid === 1'b0 && stall === 1'b0, {30'd0, stall, addr_valid}, 32'd0);
        rst_n = 1'b1;
        step();
        // R1: nothing held after reset, indexed request uses zero
        request("R1 no prefix", 2'd0, 1'b1, 16'h0008, 32'h0000_1000, 32'h0000_1008, 1'b0);

        // R2 R3 R4 R5: table
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  vs;  logic vm; logic [1:0] vsc;
            logic [15:0] vi, vd; logic [31:0] vb, ve;
            {vs, vm, vsc, vi, vd, vb} = VEC[i];
            ve = ea(vb, vm, vsc, vi, vd);
            if (vm) prefix(vi, vsc);
            request($sformatf("R2 R5 vec%0d", i), vs, vm, vd, vb, ve, slow(vb, ve, vd));
        end

        // R6: base+disp mode ignores a held index; R7: prefix gone afterwards
        prefix(16'h0100, 2'd2);
        request("R6 ignore index", 2'd1, 1'b0, 16'h0002, 32'h0000_2000, 32'h0000_2002, 1'b0);
        request("R7 consumed", 2'd1, 1'b1, 16'h0002, 32'h0000_2000, 32'h0000_2002, 1'b0);

        // R8: flush drops a held prefix
        prefix(16'h0040, 2'd0);
        flush = 1'b1; step(); flush = 1'b0;
        request("R8 prefix flushed", 2'd2, 1'b1, 16'h0000, 32'h0000_0300, 32'h0000_0300, 1'b0);

        // R8: flush during stall cancels the result
        set_base(2'd0, 32'h0000_0400);
        req_mode = 1'b0; req_disp = 16'hFFFF; req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        chk("R8 stall seen", stall === 1'b1, {31'd0, stall}, 32'd1);
        flush = 1'b1; step(); flush = 1'b0;
        chk("R8 no valid after flush", addr_valid === 1'b0 && stall === 1'b0, {30'd0, stall, addr_valid}, 32'd0);
        step();
        chk("R8 still idle", addr_valid === 1'b0, {31'd0, addr_valid}, 32'd0);

        // R9: request during stall is ignored
        set_base(2'd1, 32'h0001_FFFF);
        req_mode = 1'b0; req_disp = 16'h0001; req_valid = 1'b1;
        step();
        chk("R9 stall", stall === 1'b1, {31'd0, stall}, 32'd1);
        req_disp = 16'h0002;
        step();
        req_valid = 1'b0;
        chk("R9 first result", addr_valid === 1'b1 && addr === 32'h0002_0000, addr, 32'h0002_0000);
        step();
        chk("R9 no second result", addr_valid === 1'b0 && stall === 1'b0, {30'd0, stall, addr_valid}, 32'd0);

        // R10: prefix alongside a request is kept for the next one
        set_base(2'd3, 32'h0000_0500);
        pfx_valid = 1'b1; pfx_index = 16'h0003; pfx_scale = 2'd1;
        req_mode = 1'b1; req_disp = 16'h0000; req_valid = 1'b1;
        step();
        pfx_valid = 1'b0; req_valid = 1'b0;
        chk("R10 same-cycle prefix unused", addr_valid === 1'b1 && addr === 32'h0000_0500, addr, 32'h0000_0500);
        step();
        request("R10 prefix kept", 2'd3, 1'b1, 16'h0000, 32'h0000_0500, 32'h0000_0506, 1'b0);

        // R3: back-to-back requests
        set_base(2'd0, 32'h0007_0010);
        req_mode = 1'b0; req_disp = 16'h0001; req_valid = 1'b1;
        step();
        chk("R3 b2b first", addr_valid === 1'b1 && addr === 32'h0007_0011, addr, 32'h0007_0011);
        req_disp = 16'h0005;
        step();
        req_valid = 1'b0;
        chk("R3 b2b second", addr_valid === 1'b1 && addr === 32'h0007_0015, addr, 32'h0007_0015);
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule